// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns one burst request into the list of column addresses that an SDRAM burst touches, one address per clock. A request carries a start column, a 3-bit length code and an ordering select. While the burst runs, the block presents a valid strobe, the column for the current beat and the beat's index. It raises a done flag together with the last beat.

Every burst stays inside the aligned group of burst-length words that holds the start column. The first beat is always the start column itself, so the requested word arrives first. The ordering select decides how the other words of the group follow. In linear order the low address bits count upward from the start offset and wrap inside the group. In interleaved order, beat k uses the start offset XOR k. A memory controller uses the block to generate column addresses or data-word indices for each beat of a transfer.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `busy`, `beat_valid` and `done` are low.
- R2: A `start` sampled high at a rising edge while `busy` is low begins a burst. From the next cycle on, `busy` and `beat_valid` are high, and the first beat shows `beat_col` equal to the requested `start_col` and `beat_idx` equal to 0.
- R3: `len_code` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Codes 4 to 7 give 8 beats. Beats occur on consecutive cycles.
- R4: For a burst of length L, every beat keeps the column bits above the low log2(L) bits equal to those of `start_col`.
- R5: With `interleave` low, beat k carries low bits equal to (start offset + k) mod L, where the start offset is `start_col` mod L.
- R6: With `interleave` high, beat k carries low bits equal to the start offset XOR k.
- R7: For lengths 1 and 2, both values of `interleave` give the same column sequence.
- R8: `done` is high on the final beat only. `busy` is low in the cycle after it. A `start` sampled in that idle cycle is accepted.
- R9: A `start` sampled while `busy` is high is ignored. The running burst continues unchanged, and a `start` that has been dropped before the burst ends starts no burst afterwards.
- R10: `beat_idx` counts 0, 1, ..., L-1 across the beats of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request, taken when idle |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Length code: 0→1, 1→2, 2→4, 3 and up→8 |
| interleave | input | 1 | 0 linear wrap order, 1 XOR order |
| busy | output | 1 | Burst in progress |
| beat_valid | output | 1 | Current beat address is valid |
| beat_col | output | COL_W | Column address of the current beat |
| beat_idx | output | 3 | Index of the current beat |
| done | output | 1 | High on the last beat |

## Verification
The embedded assertions check on every cycle that an accepted request yields its start column at index 0, and that beat indices step by one. They also check that the upper column bits stay fixed during a burst, that done falls only on the final index, and that busy drops right after done. The actual word orderings can only be shown by the bench's scenarios: linear wrap against XOR order, each length code including the codes above 3, and start offsets at the edges of the group. The bench scenarios also cover requests ignored during a burst and restarting in the idle cycle after done.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  output logic             busy,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic [2:0]       beat_idx,
  output logic             done
);

  localparam int LOW_W = 3;

  logic             busy_q;
  logic             ilv_q;
  logic [COL_W-1:0] col_q;
  logic [LOW_W-1:0] last_q;
  logic [LOW_W-1:0] cnt_q;
  logic [LOW_W-1:0] last_d;
  logic [LOW_W-1:0] off;
  logic [LOW_W-1:0] low_lin;
  logic [LOW_W-1:0] low_xor;
  logic [LOW_W-1:0] low_sel;
  logic             accept;
  logic             fin;

  always_comb begin
    case (len_code)
      3'd0:    last_d = 3'd0;
      3'd1:    last_d = 3'd1;
      3'd2:    last_d = 3'd3;
      default: last_d = 3'd7;
    endcase
  end

  assign accept = start & ~busy_q;
  assign fin    = busy_q & (cnt_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ilv_q  <= 1'b0;
      col_q  <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      ilv_q  <= interleave;
      col_q  <= start_col;
      last_q <= last_d;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (fin) busy_q <= 1'b0;
      else     cnt_q  <= cnt_q + 3'd1;
    end
  end

  assign off     = col_q[LOW_W-1:0] & last_q;
  assign low_lin = (off + cnt_q) & last_q;
  assign low_xor = (off ^ cnt_q) & last_q;
  assign low_sel = ilv_q ? low_xor : low_lin;

  assign beat_col   = {col_q[COL_W-1:LOW_W], (col_q[LOW_W-1:0] & ~last_q) | low_sel};
  assign beat_idx   = cnt_q;
  assign busy       = busy_q;
  assign beat_valid = busy_q;
  assign done       = fin;

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (beat_valid && beat_col == $past(start_col) && beat_idx == 3'd0));

  a_r10_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && beat_idx == $past(beat_idx) + 3'd1));

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (beat_col[COL_W-1:LOW_W] == $past(beat_col[COL_W-1:LOW_W])));

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r8_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && beat_idx == last_q));

  a_r1_valid_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid == busy);

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             interleave = 1'b0;
  logic             busy, beat_valid, done;
  logic [COL_W-1:0] beat_col;
  logic [2:0]       beat_idx;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_code(len_code), .interleave(interleave), .busy(busy),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_idx(beat_idx), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_col(input int col, input int len, input bit il, input int k);
    int m, o, lo;
    m  = len - 1;
    o  = col & m;
    lo = il ? ((o ^ k) & m) : ((o + k) & m);
    return (col & ~m) | lo;
  endfunction

  // Runs one burst; inputs change at negedge, outputs sampled at negedge.
  task automatic run_burst(input int col, input logic [2:0] code, input bit il, input string req);
    int len;
    len = blen(code);
    start_col  = col[COL_W-1:0];
    len_code   = code;
    interleave = il;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      check(beat_valid && busy, {req, " valid"}, int'(beat_valid), 1);
      check(int'(beat_col) == exp_col(col, len, il, k), {req, " col"}, int'(beat_col), exp_col(col, len, il, k));
      check(int'(beat_idx) == k, "R10 idx", int'(beat_idx), k);
      check(done == (k == len - 1), "R8 done", int'(done), int'(k == len - 1));
      @(negedge clk);
    end
    check(!busy && !beat_valid, "R8 idle after done", int'(busy), 0);
  endtask

  task automatic test_reset();
    check(!busy && !beat_valid && !done, "R1 reset", int'(busy) + int'(beat_valid) + int'(done), 0);
  endtask

  task automatic test_lengths();
    run_burst(5, 3'd0, 1'b0, "R3 len1");
    run_burst(5, 3'd1, 1'b0, "R3 len2");
    run_burst(6, 3'd2, 1'b0, "R3 len4");
    run_burst(13, 3'd3, 1'b0, "R3 len8");
    run_burst(13, 3'd5, 1'b0, "R3 code5");
    run_burst(10, 3'd7, 1'b1, "R3 code7");
  endtask

  task automatic test_orders();
    run_burst(4, 3'd2, 1'b0, "R5 lin off0");
    run_burst(7, 3'd2, 1'b0, "R5 lin off3");
    run_burst(10'h3FB, 3'd3, 1'b0, "R5 R4 lin top");
    run_burst(6, 3'd2, 1'b1, "R6 xor len4");
    run_burst(10'h2A5, 3'd3, 1'b1, "R6 R4 xor len8");
    run_burst(10'h3FF, 3'd3, 1'b1, "R6 xor last");
  endtask

  task automatic test_short_type();
    run_burst(11, 3'd1, 1'b1, "R7 len2 xor");
    run_burst(11, 3'd0, 1'b1, "R7 len1 xor");
  endtask

  task automatic test_ignore();
    start_col = 10'd16; len_code = 3'd2; interleave = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k == 1) begin
        start_col = 10'd99; len_code = 3'd0; interleave = 1'b1; start = 1'b1;
      end else if (k == 2) start = 1'b0;
      check(int'(beat_col) == 16 + k, "R9 col", int'(beat_col), 16 + k);
      check(done == (k == 3), "R9 done", int'(done), int'(k == 3));
      @(negedge clk);
    end
    check(!busy, "R9 no extra burst", int'(busy), 0);
    @(negedge clk);
    check(!busy, "R9 still idle", int'(busy), 0);
  endtask

  task automatic test_restart();
    start_col = 10'd40; len_code = 3'd1; interleave = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done, "R8 done", int'(done), 1);
    @(negedge clk);
    check(!busy, "R8 idle", int'(busy), 0);
    run_burst(51, 3'd2, 1'b0, "R8 restart R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_lengths();
    test_orders();
    test_short_type();
    test_ignore();
    test_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule